// File: doc/BRIEF.md
# Settable 24-Hour Timekeeping Core

This block keeps time of day as three binary fields (hours 0 to 23, minutes and seconds 0 to 59). It is paced by a strobe that arrives twenty times per second. A divide-by-ten counter on that strobe toggles a half-second phase flag, and the seconds field advances once on each full period of that flag. The phase flag also serves as the blink cadence for a display.

Two debounced, active-low keys set the time. The mode key walks through three states: running, minute adjust and hour adjust. The increment key bumps the field that is being adjusted. A key acts when it is released, not when it is pressed. Entering adjustment zeroes the seconds and freezes timekeeping. A 6-bit per-digit mask tells the display which digit pairs should blink.

Top module: `clock24_core`

## Requirements
- R1: The half-second flag resets to 0 and inverts on every tenth tick strobe. It never changes in a cycle without a tick.
- R2: While running, seconds advance by one on the tick at which the half-second flag goes from 0 to 1, so the first advance after reset comes on the 10th tick and later ones every 20 ticks.
- R3: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. Each wrap while running adds one to the next field, so 23:59:59 is followed by 00:00:00.
- R4: Releasing the mode key while running enters minute adjust. This sets the setting flag, clears seconds to 0 and sets the blink mask to 6'b110011. In the mask, bits 5:4 are the hour digits, bits 3:2 the minute digits and bits 1:0 the second digits, and 0 means blink.
- R5: In minute adjust, each increment-key release adds one to minutes, wrapping 59 to 0 without touching hours.
- R6: A mode release in minute adjust enters hour adjust with mask 6'b001111. There, each increment release adds one to hours, wrapping 23 to 0.
- R7: A mode release in hour adjust returns to running, clears the setting flag and sets the mask to 6'b111111.
- R8: A key acts only on its low-to-high transition. Holding a key low changes no output.
- R9: If both keys are released in the same cycle, only the mode key acts and the increment is dropped.
- R10: During adjustment the tick counter and half-second flag keep running, while seconds stay at 0.
- R11: Synchronous active-high reset gives 00:00:00, half flag 0, setting flag 0 and mask 6'b111111.
- R12: If entering minute adjust falls in the same cycle as a seconds advance, the entry wins: seconds become 0 and nothing carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe, 20 per second |
| key_mode_n | input | 1 | Debounced mode key, active low |
| key_inc_n | input | 1 | Debounced increment key, active low |
| hours | output | 5 | Hour field, 0 to 23 |
| minutes | output | 6 | Minute field, 0 to 59 |
| seconds | output | 6 | Second field, 0 to 59 |
| half_sec | output | 1 | Half-second phase flag |
| setting | output | 1 | High while in either adjust state |
| blink_mask | output | 6 | Per-digit display enable, 0 = blink |

## Verification
A seconds advance and entry into minute adjust can fall on the same clock edge. The bench provokes this by holding the mode key low and then releasing it in exactly the cycle that carries the tick on which the half flag rises. It expects seconds 0, minutes unchanged, the setting flag high and the half flag still toggled. A second collision, both keys released together, checks that mode wins and that the minute field does not move.

// File: rtl/clock24_pkg.sv
package clock24_pkg;
   typedef enum logic [1:0] {
      ST_RUN = 2'd0,
      ST_MIN = 2'd1,
      ST_HR  = 2'd2
   } adj_state_t;

   localparam logic [5:0] MASK_RUN = 6'b111111;
   localparam logic [5:0] MASK_MIN = 6'b110011;
   localparam logic [5:0] MASK_HR  = 6'b001111;
endpackage

// File: rtl/key_release.sv
module key_release #(
   parameter int NKEYS = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NKEYS-1:0] key_n,
   output logic [NKEYS-1:0] released
);
   logic [NKEYS-1:0] prev_n;

   for (genvar k = 0; k < NKEYS; k++) begin : g_key
      always_ff @(posedge clk) begin
         if (rst) prev_n[k] <= 1'b1;
         else     prev_n[k] <= key_n[k];
      end
      assign released[k] = ~prev_n[k] & key_n[k];

      assert_rel_edge_R8: assert property (@(posedge clk) disable iff (rst)
         released[k] |=> !released[k]);
   end
endmodule

// File: rtl/half_sec_gen.sv
module half_sec_gen #(
   parameter int TICKS_PER_HALF = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   output logic half,
   output logic rise
);
   localparam int CW = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_HALF - 1);

   logic [CW-1:0] cnt;
   logic          roll;

   initial assert (TICKS_PER_HALF >= 2) else $error("TICKS_PER_HALF too small");

   assign roll = tick && (cnt == LAST);
   assign rise = roll && !half;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         half <= 1'b0;
      end else if (tick) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            half <= ~half;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assert_half_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(half));
   assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
   parameter int MOD = 60,
   parameter int W   = $clog2(MOD)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] val,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = W'(MOD - 1);

   initial assert (MOD >= 2 && (1 << W) >= MOD) else $error("bad wrap_counter sizing");

   assign wrap = inc && !clr && (val == TOP);

   always_ff @(posedge clk) begin
      if (rst || clr)  val <= '0;
      else if (inc)    val <= (val == TOP) ? '0 : val + 1'b1;
   end

   assert_range_R3: assert property (@(posedge clk) disable iff (rst)
      val <= TOP);
   assert_step_R3: assert property (@(posedge clk) disable iff (rst)
      inc && !clr && val != TOP |=> val == $past(val) + 1'b1);
endmodule

// File: rtl/adjust_fsm.sv
module adjust_fsm
   import clock24_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       mode_rel,
   input  logic       inc_rel,
   output logic       running,
   output logic       enter_adj,
   output logic       min_bump,
   output logic       hr_bump,
   output logic [5:0] mask
);
   adj_state_t state, nxt;
   logic       inc_eff;

   assign inc_eff   = inc_rel && !mode_rel;
   assign running   = (state == ST_RUN);
   assign enter_adj = running && mode_rel;
   assign min_bump  = (state == ST_MIN) && inc_eff;
   assign hr_bump   = (state == ST_HR) && inc_eff;

   always_comb begin
      nxt = state;
      if (mode_rel) begin
         unique case (state)
            ST_RUN:  nxt = ST_MIN;
            ST_MIN:  nxt = ST_HR;
            default: nxt = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_RUN;
         mask  <= MASK_RUN;
      end else begin
         state <= nxt;
         unique case (nxt)
            ST_MIN:  mask <= MASK_MIN;
            ST_HR:   mask <= MASK_HR;
            default: mask <= MASK_RUN;
         endcase
      end
   end

   assert_state_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !mode_rel |=> $stable(state));
   assert_enter_R4: assert property (@(posedge clk) disable iff (rst)
      enter_adj |=> state == ST_MIN);
   assert_mode_wins_R9: assert property (@(posedge clk) disable iff (rst)
      mode_rel |-> !min_bump && !hr_bump);
endmodule

// File: rtl/clock24_core.sv
module clock24_core #(
   parameter int TICKS_PER_HALF = 10,
   parameter int SEC_MOD        = 60,
   parameter int MIN_MOD        = 60,
   parameter int HR_MOD         = 24,
   parameter int SW             = $clog2(SEC_MOD),
   parameter int MW             = $clog2(MIN_MOD),
   parameter int HW             = $clog2(HR_MOD)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic          key_mode_n,
   input  logic          key_inc_n,
   output logic [HW-1:0] hours,
   output logic [MW-1:0] minutes,
   output logic [SW-1:0] seconds,
   output logic          half_sec,
   output logic          setting,
   output logic [5:0]    blink_mask
);
   logic [1:0] rel;
   logic       rise, running, enter_adj, min_bump, hr_bump;
   logic       sec_step, sec_wrap, min_wrap, hr_wrap;

   key_release #(.NKEYS(2)) u_keys (
      .clk(clk), .rst(rst),
      .key_n({key_inc_n, key_mode_n}),
      .released(rel)
   );

   half_sec_gen #(.TICKS_PER_HALF(TICKS_PER_HALF)) u_half (
      .clk(clk), .rst(rst), .tick(tick), .half(half_sec), .rise(rise)
   );

   adjust_fsm u_fsm (
      .clk(clk), .rst(rst), .mode_rel(rel[0]), .inc_rel(rel[1]),
      .running(running), .enter_adj(enter_adj),
      .min_bump(min_bump), .hr_bump(hr_bump), .mask(blink_mask)
   );

   // entry into adjustment takes precedence over a coinciding seconds step
   assign sec_step = rise && running && !enter_adj;

   wrap_counter #(.MOD(SEC_MOD), .W(SW)) u_sec (
      .clk(clk), .rst(rst), .clr(enter_adj), .inc(sec_step),
      .val(seconds), .wrap(sec_wrap)
   );
   wrap_counter #(.MOD(MIN_MOD), .W(MW)) u_min (
      .clk(clk), .rst(rst), .clr(1'b0), .inc(sec_wrap || min_bump),
      .val(minutes), .wrap(min_wrap)
   );
   wrap_counter #(.MOD(HR_MOD), .W(HW)) u_hr (
      .clk(clk), .rst(rst), .clr(1'b0), .inc((min_wrap && running) || hr_bump),
      .val(hours), .wrap(hr_wrap)
   );

   assign setting = !running;

   logic unused_ok;
   assign unused_ok = hr_wrap;

   assert_sec_zero_R4: assert property (@(posedge clk) disable iff (rst)
      setting |-> seconds == '0);
   assert_min_frozen_R5: assert property (@(posedge clk) disable iff (rst)
      setting && !min_bump |=> $stable(minutes));
   assert_hr_frozen_R6: assert property (@(posedge clk) disable iff (rst)
      setting && !hr_bump |=> $stable(hours));
   assert_sec_only_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
      !rise |=> $stable(seconds) || seconds == '0);
endmodule

// File: tb/tb_clock24_core.sv
module tb_clock24_core;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic key_mode_n = 1'b1;
   logic key_inc_n = 1'b1;
   logic [4:0] hours;
   logic [5:0] minutes, seconds;
   logic half_sec, setting;
   logic [5:0] blink_mask;

   always #2 clk = ~clk;

   clock24_core dut (
      .clk(clk), .rst(rst), .tick(tick),
      .key_mode_n(key_mode_n), .key_inc_n(key_inc_n),
      .hours(hours), .minutes(minutes), .seconds(seconds),
      .half_sec(half_sec), .setting(setting), .blink_mask(blink_mask)
   );

   typedef struct {
      string tag;
      int hr, mn, sc, half, set;
      logic [5:0] mask;
   } exp_t;

   exp_t q[$];
   event chk_ev;
   int total = 0, bad = 0;
   bit done = 0;

   // monitor: pops expected items and compares with the outputs
   always @(chk_ev) begin
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (hours != e.hr[4:0] || minutes != e.mn[5:0] || seconds != e.sc[5:0] ||
             half_sec != e.half[0] || setting != e.set[0] || blink_mask != e.mask) begin
            bad++;
            $display("FAIL %s: got %0d:%0d:%0d half=%0d set=%0d mask=%b exp %0d:%0d:%0d half=%0d set=%0d mask=%b",
                     e.tag, hours, minutes, seconds, half_sec, setting, blink_mask,
                     e.hr, e.mn, e.sc, e.half, e.set, e.mask);
         end
      end
   end

   task automatic expect_now(string tag, int hr, int mn, int sc, int half, int set, logic [5:0] mask);
      exp_t e;
      e.tag = tag; e.hr = hr; e.mn = mn; e.sc = sc; e.half = half; e.set = set; e.mask = mask;
      q.push_back(e);
      -> chk_ev;
      #1;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic press_mode();
      key_mode_n = 1'b0;
      repeat (3) @(negedge clk);
      key_mode_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic press_inc(int n);
      for (int i = 0; i < n; i++) begin
         key_inc_n = 1'b0;
         repeat (2) @(negedge clk);
         key_inc_n = 1'b1;
         @(negedge clk);
      end
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      expect_now("R11 reset", 0, 0, 0, 0, 0, 6'b111111);

      ticks(9);
      expect_now("R1 nine ticks no toggle", 0, 0, 0, 0, 0, 6'b111111);
      ticks(1);
      expect_now("R2 first second at tick 10", 0, 0, 1, 1, 0, 6'b111111);
      ticks(20);
      expect_now("R2 second advance after 20 more", 0, 0, 2, 1, 0, 6'b111111);

      // R8: holding the mode key has no effect until release
      key_mode_n = 1'b0;
      repeat (4) @(negedge clk);
      expect_now("R8 held key no action", 0, 0, 2, 1, 0, 6'b111111);
      key_mode_n = 1'b1;
      @(negedge clk);
      expect_now("R4 enter minute adjust", 0, 0, 0, 1, 1, 6'b110011);

      ticks(10);
      expect_now("R10 half toggles seconds hold", 0, 0, 0, 0, 1, 6'b110011);

      press_inc(59);
      expect_now("R5 minutes to 59", 0, 59, 0, 0, 1, 6'b110011);
      press_inc(1);
      expect_now("R5 minute wrap no hour carry", 0, 0, 0, 0, 1, 6'b110011);
      press_inc(59);
      expect_now("R5 minutes back to 59", 0, 59, 0, 0, 1, 6'b110011);

      // R9: both keys released together
      key_mode_n = 1'b0; key_inc_n = 1'b0;
      repeat (2) @(negedge clk);
      key_mode_n = 1'b1; key_inc_n = 1'b1;
      @(negedge clk);
      expect_now("R9 mode priority, R6 hour adjust", 0, 59, 0, 0, 1, 6'b001111);

      press_inc(23);
      expect_now("R6 hours to 23", 23, 59, 0, 0, 1, 6'b001111);
      press_inc(1);
      expect_now("R6 hour wrap", 0, 59, 0, 0, 1, 6'b001111);
      press_inc(23);
      expect_now("R6 hours back to 23", 23, 59, 0, 0, 1, 6'b001111);

      press_mode();
      expect_now("R7 back to running", 23, 59, 0, 0, 0, 6'b111111);

      ticks(1170);
      expect_now("R2 R3 at 23:59:59", 23, 59, 59, 1, 0, 6'b111111);
      ticks(20);
      expect_now("R3 full carry to midnight", 0, 0, 0, 1, 0, 6'b111111);

      // R12: mode release on the tick that would step seconds
      ticks(19);
      expect_now("R12 pre-collision", 0, 0, 0, 0, 0, 6'b111111);
      key_mode_n = 1'b0;
      @(negedge clk);
      key_mode_n = 1'b1;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      expect_now("R12 entry wins over seconds step", 0, 0, 0, 1, 1, 6'b110011);

      press_mode();
      press_mode();
      expect_now("R7 exit after collision", 0, 0, 0, 1, 0, 6'b111111);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule